// File: doc/BRIEF.md
# Watchdog Timer with Selectable Time-out Output

This block is a countdown watchdog on a small register bus. Software programs an 8-bit control register that sets a period and picks what happens when the period runs out. The count starts again on every edge of an external kick pin, and on every write of the control register. If no restart arrives in time, the block records the event in a sticky flag. It then either holds a latched active-low interrupt or drives a timed active-low reset pulse.

The interrupt pin is shared with a frequency-test waveform that arrives from outside the block. An interrupt-steered watchdog takes that pin over. A power-fail input disarms the watchdog at once. The tick length and the reset-pulse length are parameters counted in clock cycles, so the same code serves silicon-rate periods and short simulation runs.

Top module: `wdt_steer`

## Requirements
- R1: The control register (address 0) is decoded as bit 7 steer, bits 6:2 multiplier M, bits 1:0 resolution code C. When M is not 0, a time-out occurs exactly M × TICK_CYC × 4^C clock edges after the edge that restarted the count. Every time-out sets the flag.
- R2: With M = 0 the watchdog never times out, whatever the resolution code is.
- R3: A time-out with steer = 0 latches the interrupt: `irq_ft_n` goes low after the time-out edge and counting stops. `sys_rst_n` is unaffected.
- R4: A latched interrupt is released only by writing 00h to address 0. A write of any other value leaves `irq_ft_n` low.
- R5: A time-out with steer = 1 drives `sys_rst_n` low for exactly PULSE_CYC cycles. At the edge where the pulse ends, the control register and the frequency-test enable both return to 0. `irq_ft_n` is not pulled low by this path.
- R6: Every edge, rising or falling, of `kick_in` restarts the count. The restart takes effect on the third clock edge after the pin changes: two flops resynchronize the pin and a third detects the edge.
- R7: A write to address 0 restarts the count on the write edge. Rewriting the same value acts as a software kick.
- R8: The flag is bit 7 of the flags register (address 1; other bits read 0). A read returns the flag and clears it, unless a time-out occurs on the same edge, in which case the flag stays set.
- R9: While `pwr_fail` is high, the control register is held at 0, writes to it are ignored, a latched interrupt is released, and a running reset pulse ends. The flag and the frequency-test enable are kept.
- R10: Frequency-test enable is bit 0 of address 2. With it set, `irq_ft_n` follows `ftest_wave` only while no interrupt is latched and the watchdog is not armed for interrupt steering (M ≠ 0 with steer = 0). Otherwise `irq_ft_n` is high, or low while an interrupt is latched.
- R11: After reset all registers read 0, `irq_ft_n` and `sys_rst_n` are high, and `rd_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe; data appears one cycle later |
| addr | input | 2 | Register select: 0 control, 1 flags, 2 frequency-test enable |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Registered read data; 0 in cycles without a read |
| kick_in | input | 1 | Asynchronous kick pin; each edge restarts the count |
| pwr_fail | input | 1 | Power-fail indication, active high |
| ftest_wave | input | 1 | Frequency-test waveform to share onto the interrupt pin |
| irq_ft_n | output | 1 | Active-low interrupt, shared with the frequency-test waveform |
| sys_rst_n | output | 1 | Active-low timed reset pulse |

## Verification
The properties assume that the bus carries at most one write or read per cycle to a decoded address. They also assume that `pwr_fail` is a clean synchronous level. A pulse ended by power failure is exempt from the pulse-length check, so the stimulus raises `pwr_fail` only at cycle boundaries.

The stimulus holds `kick_in` low through reset, so no false edge appears after reset is released. It changes the kick pin only while the watchdog is armed. All inputs are driven on falling clock edges, which keeps them stable across every rising edge the properties sample.

// File: rtl/wdt_steer_pkg.sv
package wdt_steer_pkg;

    // Control register layout: steering, multiplier, resolution
    typedef struct packed {
        logic       steer;   // 1: timed reset pulse, 0: latched interrupt
        logic [4:0] mult;    // period multiplier, 0 disarms
        logic [1:0] res;     // base tick = TICK_CYC * 4^res
    } wd_cfg_t;

    typedef enum logic [1:0] {
        ADR_WDOG  = 2'd0,
        ADR_FLAGS = 2'd1,
        ADR_FTEST = 2'd2,
        ADR_NONE  = 2'd3
    } reg_addr_e;

    // Cycles per base tick for a resolution code
    function automatic logic [31:0] base_cycles(input logic [1:0] res, input logic [31:0] tick);
        return tick << {res, 1'b0};
    endfunction

    // Armed with time-out routed to the interrupt pin
    function automatic logic irq_steered(input wd_cfg_t c);
        return (c.mult != 5'd0) && !c.steer;
    endfunction

endpackage

// File: rtl/wdt_kick_sync.sv
module wdt_kick_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic kick_in,
    output logic kick_edge
);
    // chain[STAGES-1] is the resynchronized level, chain[STAGES] its history
    logic [STAGES:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-1:0], kick_in};
    end

    assign kick_edge = chain[STAGES-1] ^ chain[STAGES];
endmodule

// File: rtl/wdt_countdown.sv
module wdt_countdown
    import wdt_steer_pkg::*;
#(
    parameter int unsigned TICK_CYC = 15_625_000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       run,
    input  logic       restart,
    input  logic [4:0] mult,
    input  logic [1:0] res,
    output logic       expire
);
    localparam longint unsigned MAX_BASE = 64'(TICK_CYC) * 64;
    localparam int PRE_W = $clog2(MAX_BASE);

    logic [PRE_W-1:0] pre_q;
    logic [4:0]       ticks_q;
    logic [31:0]      base_w;
    logic             tick_w;

    always_comb begin
        base_w = base_cycles(res, TICK_CYC);
        tick_w = (64'(pre_q) == (64'(base_w) - 64'd1));
        expire = run && !restart && tick_w && (ticks_q == (mult - 5'd1));
    end

    always_ff @(posedge clk) begin
        if (rst || !run || restart) begin
            pre_q   <= '0;
            ticks_q <= '0;
        end else if (tick_w) begin
            pre_q   <= '0;
            ticks_q <= ticks_q + 5'd1;
        end else begin
            pre_q   <= pre_q + 1'b1;
        end
    end
endmodule

// File: rtl/wdt_pulse_gen.sv
module wdt_pulse_gen #(
    parameter int unsigned PULSE_CYC = 25_000_000
) (
    input  logic clk,
    input  logic rst,
    input  logic abort,
    input  logic start,
    output logic active,
    output logic done
);
    localparam int CNT_W = $clog2(PULSE_CYC + 1);

    logic [CNT_W-1:0] cnt_q;

    assign done = active && (cnt_q == CNT_W'(PULSE_CYC - 1));

    always_ff @(posedge clk) begin
        if (rst || abort) begin
            active <= 1'b0;
            cnt_q  <= '0;
        end else if (start && !active) begin
            active <= 1'b1;
            cnt_q  <= '0;
        end else if (done) begin
            active <= 1'b0;
            cnt_q  <= '0;
        end else if (active) begin
            cnt_q  <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/wdt_steer.sv
module wdt_steer
    import wdt_steer_pkg::*;
#(
    parameter int unsigned TICK_CYC    = 15_625_000,
    parameter int unsigned PULSE_CYC   = 25_000_000,
    parameter int          SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic       rd_en,
    input  logic [1:0] addr,
    input  logic [7:0] wr_data,
    output logic [7:0] rd_data,
    input  logic       kick_in,
    input  logic       pwr_fail,
    input  logic       ftest_wave,
    output logic       irq_ft_n,
    output logic       sys_rst_n
);
    wd_cfg_t   cfg_q;
    logic      irq_lat_q;
    logic      flag_q;
    logic      ften_q;
    logic      kick_edge;
    logic      expire;
    logic      pulse_active;
    logic      pulse_done;
    logic      wr_wdog;
    logic      restart;
    logic      run;
    reg_addr_e adr;

    assign adr     = reg_addr_e'(addr);
    assign wr_wdog = wr_en && (adr == ADR_WDOG) && !pwr_fail;
    assign restart = wr_wdog || kick_edge;
    assign run     = (cfg_q.mult != 5'd0) && !irq_lat_q && !pulse_active && !pwr_fail;

    wdt_kick_sync #(.STAGES(SYNC_STAGES)) u_kick (
        .clk       (clk),
        .rst       (rst),
        .kick_in   (kick_in),
        .kick_edge (kick_edge)
    );

    wdt_countdown #(.TICK_CYC(TICK_CYC)) u_count (
        .clk     (clk),
        .rst     (rst),
        .run     (run),
        .restart (restart),
        .mult    (cfg_q.mult),
        .res     (cfg_q.res),
        .expire  (expire)
    );

    wdt_pulse_gen #(.PULSE_CYC(PULSE_CYC)) u_pulse (
        .clk    (clk),
        .rst    (rst),
        .abort  (pwr_fail),
        .start  (expire && cfg_q.steer),
        .active (pulse_active),
        .done   (pulse_done)
    );

    // Control register: the end of a pulse and power failure override writes
    always_ff @(posedge clk) begin
        if (rst || pwr_fail) cfg_q <= '0;
        else if (pulse_done) cfg_q <= '0;
        else if (wr_wdog)    cfg_q <= wd_cfg_t'(wr_data);
    end

    // Interrupt latch: released only by a zero write or power failure
    always_ff @(posedge clk) begin
        if (rst || pwr_fail)                    irq_lat_q <= 1'b0;
        else if (wr_wdog && wr_data == 8'h00)   irq_lat_q <= 1'b0;
        else if (expire && !cfg_q.steer)        irq_lat_q <= 1'b1;
    end

    // Sticky flag: a time-out wins over a clearing read
    always_ff @(posedge clk) begin
        if (rst)                                flag_q <= 1'b0;
        else if (expire)                        flag_q <= 1'b1;
        else if (rd_en && adr == ADR_FLAGS)     flag_q <= 1'b0;
    end

    // Frequency-test enable, cleared when a reset pulse completes
    always_ff @(posedge clk) begin
        if (rst)                                ften_q <= 1'b0;
        else if (pulse_done)                    ften_q <= 1'b0;
        else if (wr_en && adr == ADR_FTEST)     ften_q <= wr_data[0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data <= '0;
        end else if (rd_en) begin
            unique case (adr)
                ADR_WDOG:  rd_data <= cfg_q;
                ADR_FLAGS: rd_data <= {flag_q, 7'd0};
                ADR_FTEST: rd_data <= {7'd0, ften_q};
                default:   rd_data <= '0;
            endcase
        end else begin
            rd_data <= '0;
        end
    end

    // Shared pin: latched interrupt, then the test waveform if not blocked
    always_comb begin
        if (irq_lat_q)                          irq_ft_n = 1'b0;
        else if (ften_q && !irq_steered(cfg_q)) irq_ft_n = ftest_wave;
        else                                    irq_ft_n = 1'b1;
    end

    assign sys_rst_n = !pulse_active;
endmodule

// File: rtl/wdt_steer_chk.sv
module wdt_steer_chk #(
    parameter int unsigned PULSE_CYC = 25_000_000
) (
    input logic       clk,
    input logic       rst,
    input logic       wr_en,
    input logic       rd_en,
    input logic [1:0] addr,
    input logic [7:0] wr_data,
    input logic       pwr_fail,
    input logic       irq_ft_n,
    input logic       sys_rst_n,
    input logic [7:0] cfg_q,
    input logic       irq_lat_q,
    input logic       flag_q,
    input logic       expire,
    input logic       pulse_active
);
    logic [31:0] low_run;

    always_ff @(posedge clk) begin
        if (rst)            low_run <= '0;
        else if (sys_rst_n) low_run <= '0;
        else                low_run <= low_run + 32'd1;
    end

    p_flag_set_r1: assert property (@(posedge clk) disable iff (rst)
        expire |=> flag_q);

    p_off_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        (cfg_q[6:2] == 5'd0) |-> !expire);

    p_irq_sets_r3: assert property (@(posedge clk) disable iff (rst)
        (expire && !cfg_q[7]) |=> (irq_lat_q && !irq_ft_n && sys_rst_n));

    p_exclusive_r3: assert property (@(posedge clk) disable iff (rst)
        !(irq_lat_q && pulse_active));

    p_irq_sticky_r4: assert property (@(posedge clk) disable iff (rst)
        (irq_lat_q && !pwr_fail && !(wr_en && addr == 2'd0 && wr_data == 8'h00)) |=> irq_lat_q);

    p_pulse_len_r5: assert property (@(posedge clk) disable iff (rst)
        ($rose(sys_rst_n) && !$past(pwr_fail)) |-> (low_run == PULSE_CYC));

    p_cfg_clear_r5: assert property (@(posedge clk) disable iff (rst)
        $fell(pulse_active) |-> (cfg_q == 8'h00));

    p_flag_clear_r8: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr == 2'd1 && !expire) |=> !flag_q);

    p_pwr_clear_r9: assert property (@(posedge clk) disable iff (rst)
        pwr_fail |=> (cfg_q == 8'h00 && !irq_lat_q && sys_rst_n));

    p_ft_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (cfg_q[6:2] != 5'd0 && !cfg_q[7] && !irq_lat_q) |-> irq_ft_n);
endmodule

bind wdt_steer wdt_steer_chk #(.PULSE_CYC(PULSE_CYC)) chk_i (
    .clk          (clk),
    .rst          (rst),
    .wr_en        (wr_en),
    .rd_en        (rd_en),
    .addr         (addr),
    .wr_data      (wr_data),
    .pwr_fail     (pwr_fail),
    .irq_ft_n     (irq_ft_n),
    .sys_rst_n    (sys_rst_n),
    .cfg_q        (cfg_q),
    .irq_lat_q    (irq_lat_q),
    .flag_q       (flag_q),
    .expire       (expire),
    .pulse_active (pulse_active)
);

// File: tb/wdt_steer_tb_top.sv
`timescale 1ns/1ps
module wdt_steer_tb_top;
    localparam int unsigned TICK  = 2;
    localparam int unsigned PULSE = 10;
    localparam int K_IRQ = 0;
    localparam int K_RST = 1;
    localparam int K_RD  = 2;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       kick_in = 1'b0;
    logic       pwr_fail = 1'b0;
    logic       ftest_wave = 1'b0;
    logic       irq_ft_n;
    logic       sys_rst_n;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;

    typedef struct {
        int         at;
        int         kind;
        logic [7:0] val;
        string      req;
    } exp_t;
    exp_t sb_q[$];

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    wdt_steer #(.TICK_CYC(TICK), .PULSE_CYC(PULSE), .SYNC_STAGES(2)) dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wr_data(wr_data), .rd_data(rd_data), .kick_in(kick_in),
        .pwr_fail(pwr_fail), .ftest_wave(ftest_wave),
        .irq_ft_n(irq_ft_n), .sys_rst_n(sys_rst_n)
    );

    function automatic logic [7:0] pick(input int kind);
        case (kind)
            K_IRQ:   return {7'd0, irq_ft_n};
            K_RST:   return {7'd0, sys_rst_n};
            default: return rd_data;
        endcase
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // Monitor: compares queued expectations against outputs mid-cycle
    initial begin
        forever begin
            @(negedge clk);
            #1;
            for (int i = sb_q.size() - 1; i >= 0; i--) begin
                if (sb_q[i].at == cyc) begin
                    logic [7:0] act;
                    act = pick(sb_q[i].kind);
                    checks++;
                    if (act !== sb_q[i].val) begin
                        errors++;
                        $display("FAIL %s kind %0d cyc %0d actual %h expected %h",
                                 sb_q[i].req, sb_q[i].kind, cyc, act, sb_q[i].val);
                    end
                    sb_q.delete(i);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual running expected finished");
        finish_run();
    end

    task automatic expect_at(input int at, input int kind, input logic [7:0] val, input string req);
        exp_t e;
        e.at = at; e.kind = kind; e.val = val; e.req = req;
        sb_q.push_back(e);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d, output int e);
        wr_en = 1'b1; addr = a; wr_data = d;
        @(negedge clk);
        e = cyc;
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, input logic [7:0] exp_v, input string req);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        expect_at(cyc, K_RD, exp_v, req);
    endtask

    task automatic wait_until(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_irq();
        int e;
        wr(2'd0, 8'h00, e);
        rd(2'd1, 8'h80, "R8");
    endtask

    initial begin
        int e;
        int e2;
        int p;
        logic [7:0] vals [4] = '{8'h05, 8'h0A, 8'h07, 8'h7C};
        int         pers [4] = '{8, 64, 128, 62};

        step(4);
        rst = 1'b0;
        step(1);
        // R11: reset state
        expect_at(cyc, K_IRQ, 8'h01, "R11");
        expect_at(cyc, K_RST, 8'h01, "R11");
        expect_at(cyc, K_RD, 8'h00, "R11");
        step(1);
        rd(2'd0, 8'h00, "R11");
        rd(2'd1, 8'h00, "R11");
        rd(2'd2, 8'h00, "R11");

        // R1/R3: mult 3, res 0, interrupt steering -> 6 cycles
        wr(2'd0, 8'h0C, e);
        expect_at(e + 5, K_IRQ, 8'h01, "R1");
        expect_at(e + 6, K_IRQ, 8'h00, "R3");
        expect_at(e + 6, K_RST, 8'h01, "R3");
        wait_until(e + 8);
        // R8: flag read then cleared
        rd(2'd1, 8'h80, "R8");
        rd(2'd1, 8'h00, "R8");
        // R4: non-zero write keeps interrupt
        wr(2'd0, 8'h0C, e);
        expect_at(e, K_IRQ, 8'h00, "R4");
        expect_at(e + 10, K_IRQ, 8'h00, "R4");
        wait_until(e + 11);
        wr(2'd0, 8'h00, e);
        expect_at(e, K_IRQ, 8'h01, "R4");
        step(1);

        // R2: multiplier zero never expires
        wr(2'd0, 8'h03, e);
        wait_until(e + 300);
        expect_at(cyc, K_IRQ, 8'h01, "R2");
        expect_at(cyc, K_RST, 8'h01, "R2");
        step(1);
        rd(2'd1, 8'h00, "R2");

        // R1: resolution codes and multipliers
        for (int i = 0; i < 4; i++) begin
            wr(2'd0, vals[i], e);
            expect_at(e + pers[i] - 1, K_IRQ, 8'h01, "R1");
            expect_at(e + pers[i], K_IRQ, 8'h00, "R1");
            wait_until(e + pers[i] + 1);
            clear_irq();
        end

        // R7: rewriting the period restarts the count
        wr(2'd0, 8'h0C, e);
        step(3);
        wr(2'd0, 8'h0C, e2);
        expect_at(e + 6, K_IRQ, 8'h01, "R7");
        expect_at(e2 + 5, K_IRQ, 8'h01, "R7");
        expect_at(e2 + 6, K_IRQ, 8'h00, "R7");
        wait_until(e2 + 7);
        clear_irq();

        // R6: rising kick edge, restart three edges later
        wr(2'd0, 8'h0C, e);
        kick_in = 1'b1;
        expect_at(e + 6, K_IRQ, 8'h01, "R6");
        expect_at(e + 8, K_IRQ, 8'h01, "R6");
        expect_at(e + 9, K_IRQ, 8'h00, "R6");
        wait_until(e + 10);
        clear_irq();
        // R6: falling kick edge
        wr(2'd0, 8'h0C, e);
        kick_in = 1'b0;
        expect_at(e + 6, K_IRQ, 8'h01, "R6");
        expect_at(e + 8, K_IRQ, 8'h01, "R6");
        expect_at(e + 9, K_IRQ, 8'h00, "R6");
        wait_until(e + 10);
        clear_irq();

        // R5 with R10: reset steering leaves the test waveform on the pin
        ftest_wave = 1'b0;
        wr(2'd2, 8'h01, e);
        expect_at(e, K_IRQ, 8'h00, "R10");
        wr(2'd0, 8'h8C, e);
        expect_at(e, K_IRQ, 8'h00, "R10");
        expect_at(e + 5, K_RST, 8'h01, "R5");
        expect_at(e + 6, K_RST, 8'h00, "R5");
        expect_at(e + 15, K_RST, 8'h00, "R5");
        expect_at(e + 15, K_IRQ, 8'h00, "R5");
        expect_at(e + 16, K_RST, 8'h01, "R5");
        expect_at(e + 16, K_IRQ, 8'h01, "R5");
        wait_until(e + 17);
        rd(2'd0, 8'h00, "R5");
        rd(2'd2, 8'h00, "R5");
        rd(2'd1, 8'h80, "R5");

        // R10: interrupt steering blocks the waveform
        wr(2'd2, 8'h01, e);
        expect_at(e, K_IRQ, 8'h00, "R10");
        wr(2'd0, 8'h0C, e);
        expect_at(e, K_IRQ, 8'h01, "R10");
        expect_at(e + 6, K_IRQ, 8'h00, "R10");
        wait_until(e + 7);
        wr(2'd0, 8'h00, e);
        expect_at(e, K_IRQ, 8'h00, "R10");
        step(1);
        ftest_wave = 1'b1;
        step(1);
        expect_at(cyc, K_IRQ, 8'h01, "R10");
        step(1);
        ftest_wave = 1'b0;
        step(1);
        expect_at(cyc, K_IRQ, 8'h00, "R10");
        wr(2'd2, 8'h00, e);
        expect_at(e, K_IRQ, 8'h01, "R10");
        rd(2'd1, 8'h80, "R8");

        // R9: power failure releases interrupt and ignores writes
        wr(2'd0, 8'h0C, e);
        wait_until(e + 7);
        expect_at(cyc, K_IRQ, 8'h00, "R9");
        pwr_fail = 1'b1;
        wr(2'd0, 8'h0C, p);
        expect_at(p, K_IRQ, 8'h01, "R9");
        step(1);
        pwr_fail = 1'b0;
        step(1);
        rd(2'd0, 8'h00, "R9");
        rd(2'd1, 8'h80, "R9");

        // R9: power failure ends a running reset pulse
        wr(2'd0, 8'h8C, e);
        wait_until(e + 8);
        expect_at(cyc, K_RST, 8'h00, "R5");
        pwr_fail = 1'b1;
        step(1);
        expect_at(cyc, K_RST, 8'h01, "R9");
        pwr_fail = 1'b0;
        step(1);
        rd(2'd0, 8'h00, "R9");
        step(3);

        if (sb_q.size() != 0) begin
            checks++;
            errors++;
            $display("FAIL unchecked expectations actual %0d expected 0", sb_q.size());
        end
        finish_run();
    end
endmodule